// File: doc/BRIEF.md
# Clock Source Stop Control Register

This block is an 8-bit control register that starts and stops three clock sources: the high-speed external source (crystal oscillator or external clock input), the low-speed subsystem source (crystal oscillator or external clock input) and the high-speed on-chip oscillator. Software writes and reads it as a whole byte. Each of the three control bits drives a stop line to its oscillator. A 1 stops the source or marks its external input invalid. A 0 lets it run.

Two side inputs report which clock the CPU and peripherals are using. `cpuOnSub` is high when the subsystem clock is selected. When it is low, `mainOnExt` picks between the high-speed external source (high) and the on-chip oscillator (low). The register refuses any write that would stop the source in use. A write that clears the external stop bit needs the settling-time configuration to be valid. No write is taken at all until the run-mode register has been written. Each bit is guarded on its own, so one write can apply some bits and refuse others. Any refusal raises a one-cycle rejection flag. When the external source restarts, its ready flag waits for the settling-status input.

Top module: `clk_src_gate_reg`

## Requirements
- R1: After reset, `rdData` reads 0xC0, `extHsStop` and `subStop` are 1, `intHsStop` is 0, and `extHsReady` and `writeRejected` are 0.
- R2: A write with `wrEn` high takes the whole byte. Bit 7 is the external high-speed stop, bit 6 the subsystem stop and bit 0 the on-chip oscillator stop, with 1 meaning stop. The new value shows on `rdData` and on the three stop outputs one cycle after the write edge.
- R3: Setting bit 7 from 0 to 1 is accepted only when `cpuOnSub`=1, or when `cpuOnSub`=0 and `mainOnExt`=0. Otherwise bit 7 keeps its value.
- R4: Setting bit 6 from 0 to 1 is accepted only when `cpuOnSub`=0. Otherwise bit 6 keeps its value.
- R5: Setting bit 0 from 0 to 1 is accepted only when `cpuOnSub`=1, or when `cpuOnSub`=0 and `mainOnExt`=1. Otherwise bit 0 keeps its value.
- R6: While `runModeWritten` is 0, every write leaves the register unchanged and raises `writeRejected` for one cycle.
- R7: Clearing bit 7 from 1 to 0 is accepted only when `settleCfgValid`=1. Clearing bit 6 or bit 0 is always accepted.
- R8: `extHsReady` is 0 while bit 7 is 1. It drops to 0 in the cycle after any write that changes bit 7. It then rises only one cycle after an edge at which `settleDone` is 1 and bit 7 is 0.
- R9: Bits 5 to 1 always read 0, whatever is written to them.
- R10: Each bit is guarded separately. `writeRejected` is high for exactly the one cycle after a write in which at least one bit change was refused. Writing a bit with the value it already holds is never a refusal.
- R11: Reads have no side effects, and the register holds its value on every cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Byte write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Current register contents |
| cpuOnSub | input | 1 | CPU/peripheral clock is the subsystem clock |
| mainOnExt | input | 1 | Main clock is the external high-speed source (used when cpuOnSub=0) |
| runModeWritten | input | 1 | Run-mode register has been written since reset |
| settleCfgValid | input | 1 | Settling-time selection is configured or kept at default |
| settleDone | input | 1 | External high-speed source settling complete |
| extHsStop | output | 1 | Stop for the external high-speed source |
| subStop | output | 1 | Stop for the subsystem source |
| intHsStop | output | 1 | Stop for the on-chip high-speed oscillator |
| extHsReady | output | 1 | External high-speed source running and settled |
| writeRejected | output | 1 | One-cycle pulse after a refused or ignored write |

## Verification
Register contents, stop lines and the rejection pulse all update at the write edge. The bench drives each write at a falling edge and samples at the next falling edge, one edge later, then samples once more a cycle later to confirm the pulse has cleared. The ready flag is one register behind `settleDone`, so the bench changes `settleDone` at a falling edge and expects the flag one falling edge later. A sweep covers every start state, every written value, both clock selections and both configuration states, and compares against a per-bit model of the guards.

// File: rtl/clk_src_gate_pkg.sv
package clk_src_gate_pkg;

  localparam int REG_W   = 8;
  localparam int NUM_SRC = 3;

  // source index order: 0 external high-speed, 1 subsystem, 2 on-chip oscillator
  localparam int SRC_HS  = 0;
  localparam int SRC_SUB = 1;
  localparam int SRC_INT = 2;

  localparam logic [REG_W-1:0] RESET_VAL = 8'hC0;

  function automatic int srcBit(input int idx);
    case (idx)
      SRC_HS:  return 7;
      SRC_SUB: return 6;
      default: return 0;
    endcase
  endfunction

  typedef struct packed {
    logic [NUM_SRC-1:0] load;
    logic [NUM_SRC-1:0] value;
    logic               reject;
  } ctlStrobes_t;

endpackage

// File: rtl/clk_src_gate_guard.sv
module clk_src_gate_guard
  import clk_src_gate_pkg::*;
(
  input  logic               wrEn,
  input  logic [NUM_SRC-1:0] reqStop,
  input  logic [NUM_SRC-1:0] curStop,
  input  logic               cpuOnSub,
  input  logic               mainOnExt,
  input  logic               runModeWritten,
  input  logic               settleCfgValid,
  output ctlStrobes_t        strobes
);

  logic [NUM_SRC-1:0] setAllowed;
  logic [NUM_SRC-1:0] clearAllowed;
  logic [NUM_SRC-1:0] changeReq;
  logic [NUM_SRC-1:0] permitted;
  logic [NUM_SRC-1:0] refused;
  logic               wrOpen;

  assign wrOpen = wrEn & runModeWritten;

  always_comb begin
    setAllowed                = '0;
    clearAllowed              = '1;
    setAllowed[SRC_HS]        = cpuOnSub | ~mainOnExt;
    setAllowed[SRC_SUB]       = ~cpuOnSub;
    setAllowed[SRC_INT]       = cpuOnSub | mainOnExt;
    clearAllowed[SRC_HS]      = settleCfgValid;
  end

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign changeReq[i] = reqStop[i] ^ curStop[i];
    assign permitted[i] = reqStop[i] ? setAllowed[i] : clearAllowed[i];
    assign refused[i]   = wrOpen & changeReq[i] & ~permitted[i];
    assign strobes.load[i]  = wrOpen & changeReq[i] & permitted[i];
    assign strobes.value[i] = reqStop[i];
  end

  assign strobes.reject = (wrEn & ~runModeWritten) | (|refused);

endmodule

// File: rtl/clk_src_gate_regs.sv
module clk_src_gate_regs
  import clk_src_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ctlStrobes_t        strobes,
  input  logic               settleDone,
  output logic [NUM_SRC-1:0] stopQ,
  output logic [REG_W-1:0]   regImage,
  output logic               readyQ,
  output logic               rejectQ
);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    localparam int BITPOS = srcBit(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stopQ[i] <= RESET_VAL[BITPOS];
      else if (strobes.load[i]) stopQ[i] <= strobes.value[i];
    end
  end

  always_comb begin
    regImage = '0;
    for (int i = 0; i < NUM_SRC; i++) regImage[srcBit(i)] = stopQ[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      readyQ  <= 1'b0;
      rejectQ <= 1'b0;
    end else begin
      rejectQ <= strobes.reject;
      if (strobes.load[SRC_HS]) readyQ <= 1'b0;
      else if (stopQ[SRC_HS])   readyQ <= 1'b0;
      else if (settleDone)      readyQ <= 1'b1;
    end
  end

endmodule

// File: rtl/clk_src_gate_reg.sv
module clk_src_gate_reg
  import clk_src_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  input  logic             cpuOnSub,
  input  logic             mainOnExt,
  input  logic             runModeWritten,
  input  logic             settleCfgValid,
  input  logic             settleDone,
  output logic             extHsStop,
  output logic             subStop,
  output logic             intHsStop,
  output logic             extHsReady,
  output logic             writeRejected
);

  logic [NUM_SRC-1:0] reqStop;
  logic [NUM_SRC-1:0] stopQ;
  ctlStrobes_t        strobes;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pick
    assign reqStop[i] = wrData[srcBit(i)];
  end

  clk_src_gate_guard guard_i (
    .wrEn           (wrEn),
    .reqStop        (reqStop),
    .curStop        (stopQ),
    .cpuOnSub       (cpuOnSub),
    .mainOnExt      (mainOnExt),
    .runModeWritten (runModeWritten),
    .settleCfgValid (settleCfgValid),
    .strobes        (strobes)
  );

  clk_src_gate_regs regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .settleDone (settleDone),
    .stopQ      (stopQ),
    .regImage   (rdData),
    .readyQ     (extHsReady),
    .rejectQ    (writeRejected)
  );

  assign extHsStop = stopQ[SRC_HS];
  assign subStop   = stopQ[SRC_SUB];
  assign intHsStop = stopQ[SRC_INT];

endmodule

// File: rtl/clk_src_gate_checker.sv
module clk_src_gate_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       cpuOnSub,
  input logic       mainOnExt,
  input logic       runModeWritten,
  input logic       settleCfgValid,
  input logic       settleDone,
  input logic       extHsStop,
  input logic       subStop,
  input logic       intHsStop,
  input logic       extHsReady,
  input logic       writeRejected
);

  a_r3_keep_active_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !cpuOnSub && mainOnExt && !extHsStop) |=> !extHsStop);

  a_r4_keep_active_sub: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && cpuOnSub && !subStop) |=> !subStop);

  a_r5_keep_active_int: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !cpuOnSub && !mainOnExt && !intHsStop) |=> !intHsStop);

  a_r6_gate_before_runmode: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && !runModeWritten) |=> ($stable(rdData) && writeRejected));

  a_r7_restart_needs_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && extHsStop && !settleCfgValid) |=> extHsStop);

  a_r8_not_ready_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    extHsStop |-> !extHsReady);

  a_r8_ready_waits_settle: assert property (@(posedge clk) disable iff (!rst_n)
    !settleDone |=> !$rose(extHsReady));

  a_r9_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrData[5:1] != 5'd0) |=> (rdData[5:1] == 5'd0));

  a_r10_no_reject_same_value: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && runModeWritten && wrData[7] == extHsStop && wrData[6] == subStop
     && wrData[0] == intHsStop) |=> !writeRejected);

  a_r10_pulse_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> !writeRejected);

  a_r11_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(rdData));

endmodule

bind clk_src_gate_reg clk_src_gate_checker chk_i (.*);

// File: tb/clk_src_gate_reg_tb.sv
module clk_src_gate_reg_tb_top;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       cpuOnSub = 1'b0;
  logic       mainOnExt = 1'b0;
  logic       runModeWritten = 1'b0;
  logic       settleCfgValid = 1'b0;
  logic       settleDone = 1'b0;
  logic       extHsStop, subStop, intHsStop, extHsReady, writeRejected;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_src_gate_reg dut_i (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge (one write edge later)
  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [7:0] pack(input logic [2:0] s, input logic [4:0] junk);
    return {s[0], s[1], junk, s[2]};
  endfunction

  function automatic logic setOk(input int k, input logic cs, input logic ms);
    if (k == 0) return cs || !ms;
    if (k == 1) return !cs;
    return cs || ms;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdData", rdData, 8'hC0);
    chk("R1 stops", {extHsStop, subStop, intHsStop}, 3'b110);
    chk("R1 ready/reject", {extHsReady, writeRejected}, 2'b00);

    // R6 writes ignored before run-mode register written
    settleCfgValid = 1'b1;
    wr(8'h01);
    chk("R6 ignored", rdData, 8'hC0);
    chk("R6 reject pulse", writeRejected, 1'b1);
    @(negedge clk);
    chk("R10 pulse one cycle", writeRejected, 1'b0);

    // R11 holds across idle cycles
    runModeWritten = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 hold", rdData, 8'hC0);

    // R8 ready sequence
    wr(8'h40);
    chk("R7 restart accepted", rdData, 8'h40);
    chk("R8 ready low after restart", extHsReady, 1'b0);
    repeat (3) @(negedge clk);
    chk("R8 ready waits settle", extHsReady, 1'b0);
    settleDone = 1'b1;
    @(negedge clk);
    chk("R8 ready rises", extHsReady, 1'b1);
    wr(8'hC0);
    chk("R3 stop ext allowed", extHsStop, 1'b1);
    chk("R8 ready low when stopped", extHsReady, 1'b0);
    wr(8'h40);
    chk("R8 ready low right after restart", extHsReady, 1'b0);
    @(negedge clk);
    chk("R8 ready after settle", extHsReady, 1'b1);
    settleDone = 1'b0;
    wr(8'hC0);

    // exhaustive sweep: selection x config x start state x written value
    for (int cs = 0; cs < 2; cs++)
      for (int ms = 0; ms < 2; ms++)
        for (int cf = 0; cf < 2; cf++)
          for (int st = 0; st < 8; st++)
            for (int nv = 0; nv < 8; nv++) begin
              logic [2:0] s3, n3, e3;
              logic       expRej;
              logic [4:0] junk;
              s3 = st[2:0]; n3 = nv[2:0];
              junk = 5'(st * 3 + nv);
              // prepare start state
              settleCfgValid = 1'b1;
              cpuOnSub = 1'b1; mainOnExt = 1'b0;
              wr(pack({s3[2], 1'b0, s3[0]}, 5'd0));
              cpuOnSub = 1'b0; mainOnExt = 1'b0;
              wr(pack(s3, 5'd0));
              chk("R2 prepare", rdData, {24'd0, pack(s3, 5'd0)});
              // test write
              cpuOnSub = cs[0]; mainOnExt = ms[0]; settleCfgValid = cf[0];
              e3 = s3; expRej = 1'b0;
              for (int k = 0; k < 3; k++) begin
                if (n3[k] != s3[k]) begin
                  logic ok;
                  ok = n3[k] ? setOk(k, cs[0], ms[0]) : ((k == 0) ? cf[0] : 1'b1);
                  if (ok) e3[k] = n3[k];
                  else expRej = 1'b1;
                end
              end
              wr(pack(n3, junk));
              chk("R3/R4/R5/R7 guarded result", rdData, {24'd0, pack(e3, 5'd0)});
              chk("R2 stop outputs", {extHsStop, subStop, intHsStop}, {e3[0], e3[1], e3[2]});
              chk("R9 reserved bits", rdData[5:1], 5'd0);
              chk("R10 reject flag", writeRejected, expRej);
              @(negedge clk);
              chk("R10 reject clears", writeRejected, 1'b0);
              chk("R11 no change idle", rdData, {24'd0, pack(e3, 5'd0)});
            end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule